// File: doc/BRIEF.md
# UART Receive Sequencer with Word Packing

This block is the receive half of a serial engine. Software arms it by writing a start-read opcode into a command register. While armed, it oversamples the receive line, recovers 8N1 characters and packs them four to a 32-bit element. Full elements go into a small receive FIFO. Software polls the FIFO element count and pops elements through a data register.

When a partial element has been waiting on an idle line for 160 bit times, the block flushes it into the FIFO and raises a last-word interrupt. A FIFO level at or above a watermark raises a second interrupt. A character that arrives while the FIFO is full is dropped and sets an overflow flag.

An abort control bit disarms the receiver and discards any partial element. A force-default bit returns the whole receiver, its flags and its enables to the reset state. One level interrupt output carries the enabled flags.

Top module: `uart_rx_seq`

## Requirements
- R1: After reset, the active bit, the FIFO count and every interrupt flag read 0, and `irq` is low.
- R2: Writing the command register (offset 0x00) with opcode 1 in bits 31:27 arms the receiver, and status bit 12 (offset 0x08) then reads 1. Any other opcode is ignored. Line activity while the receiver is not armed produces no FIFO entry.
- R3: Characters use one start bit, 8 data bits sent LSB first and one stop bit, each bit `OSR` clocks long. A start bit is accepted only if the line is still low at its midpoint, so a low pulse shorter than half a bit is rejected.
- R4: Received characters fill the byte lanes of an element in order of arrival, starting at bits 7:0. The element enters the FIFO when its fourth character arrives. The FIFO status register (offset 0x18) reports the element count in bits 24:0. Reading the data register (offset 0x1C) returns the oldest element and removes it.
- R5: A partial element that waits `STALE_BITS` (160) bit times with the line idle is pushed into the FIFO with its unused lanes set to zero, and interrupt bit 27 is set.
- R6: Interrupt bit 26 is set while the FIFO count is at least `WM_LEVEL`.
- R7: A character that completes while the FIFO holds `FIFO_DEPTH` elements is discarded, and interrupt bit 28 is set.
- R8: Writing 1 to bit 1 of the control register (offset 0x04) requests an abort. That bit reads 1 in the cycle after the write and 0 from the next cycle on. At that point the receiver is disarmed, the partial element is dropped, and interrupt bits 5 and 0 are set.
- R9: The interrupt flags (offset 0x0C) are cleared by writing 1s to offset 0x10. `irq` is the OR of the flags masked by the enable register (offset 0x14).
- R10: Writing 1 to bit 0 at offset 0x20 returns the FIFO, the active bit, the flags and the enables to their reset values.
- R11: A character whose stop bit samples low is discarded. The receiver waits for the line to go high before it looks for another start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial receive line, idle high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO at the data offset) |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| irq | output | 1 | Level interrupt |

## Verification
Register writes take effect at the clock edge that samples them. Readback is combinational, so the bench reads control and status on the next falling edge, and this is how it sees the one-cycle abort-pending window. The last character of a frame is pushed about half a bit time before the frame ends, so the bench reads the FIFO count once the stop bit has been driven. The stale flush lands 160 bit times after that push, so the bench checks the count a little before and a little after that point. Flags that follow a FIFO level are checked one edge after the level changes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_STOP,
    RS_WAITHI
  } rx_state_e;

  // register byte offsets
  localparam logic [7:0] ADR_CMD   = 8'h00;
  localparam logic [7:0] ADR_CTRL  = 8'h04;
  localparam logic [7:0] ADR_STAT  = 8'h08;
  localparam logic [7:0] ADR_IRQ   = 8'h0C;
  localparam logic [7:0] ADR_ICLR  = 8'h10;
  localparam logic [7:0] ADR_IEN   = 8'h14;
  localparam logic [7:0] ADR_FSTAT = 8'h18;
  localparam logic [7:0] ADR_FDATA = 8'h1C;
  localparam logic [7:0] ADR_FDEF  = 8'h20;

  // bit positions decoded by software
  localparam int BIT_ACTIVE    = 12;
  localparam int BIT_ABORT     = 1;
  localparam int BIT_FDEF      = 0;
  localparam int IRQ_CMDDONE   = 0;
  localparam int IRQ_ABORTDONE = 5;
  localparam int IRQ_WM        = 26;
  localparam int IRQ_LAST      = 27;
  localparam int IRQ_OVF       = 28;

  localparam logic [4:0] OPC_READ = 5'd1;

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       rx_line,
  output logic       chr_vld,
  output logic [7:0] chr_data,
  output logic       busy
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    shf_q, shf_d;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_line};
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    shf_d   = shf_q;
    chr_vld = 1'b0;
    case (state_q)
      RS_IDLE: begin
        cnt_d = '0;
        bit_d = '0;
        if (!rx_s) state_d = RS_START;
      end
      RS_START: begin
        if (cnt_q == MID) begin
          cnt_d   = '0;
          state_d = rx_s ? RS_IDLE : RS_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RS_DATA: begin
        if (cnt_q == LAST) begin
          cnt_d = '0;
          shf_d = {rx_s, shf_q[7:1]};
          if (bit_q == 3'd7) state_d = RS_STOP;
          else               bit_d   = bit_q + 3'd1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RS_STOP: begin
        if (cnt_q == LAST) begin
          cnt_d = '0;
          if (rx_s) begin
            chr_vld = 1'b1;
            state_d = RS_IDLE;
          end else begin
            state_d = RS_WAITHI;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RS_WAITHI: begin
        if (rx_s) state_d = RS_IDLE;
      end
      default: state_d = RS_IDLE;
    endcase
    if (clr || !en) begin
      state_d = RS_IDLE;
      cnt_d   = '0;
      bit_d   = '0;
      chr_vld = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shf_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shf_q   <= shf_d;
    end
  end

  assign chr_data = shf_q;
  assign busy     = (state_q != RS_IDLE);

endmodule

// File: rtl/uart_rx_packer.sv
module uart_rx_packer #(
  parameter int OSR        = 16,
  parameter int STALE_BITS = 160,
  parameter int W          = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         chr_vld,
  input  logic [7:0]   chr_data,
  input  logic         line_busy,
  input  logic         fifo_full,
  output logic         push,
  output logic [W-1:0] push_data,
  output logic         last_evt,
  output logic         ovf_evt
);

  localparam int LANES      = W / 8;
  localparam int LW         = $clog2(LANES);
  localparam int STALE_CLKS = OSR * STALE_BITS;
  localparam int SW         = $clog2(STALE_CLKS + 1);

  logic [LW-1:0] lane_q, lane_d;
  logic [W-1:0]  acc_q, acc_d, acc_w;
  logic [SW-1:0] stale_q, stale_d;

  always_comb begin
    lane_d    = lane_q;
    acc_d     = acc_q;
    stale_d   = stale_q;
    push      = 1'b0;
    push_data = acc_q;
    last_evt  = 1'b0;
    ovf_evt   = 1'b0;
    acc_w     = acc_q | (W'(chr_data) << {lane_q, 3'b000});
    if (chr_vld) begin
      stale_d = '0;
      if (fifo_full) begin
        ovf_evt = 1'b1;
      end else if (lane_q == LW'(LANES - 1)) begin
        push      = 1'b1;
        push_data = acc_w;
        acc_d     = '0;
        lane_d    = '0;
      end else begin
        acc_d  = acc_w;
        lane_d = lane_q + 1'b1;
      end
    end else if (lane_q != '0 && !line_busy) begin
      if (stale_q == SW'(STALE_CLKS - 1)) begin
        if (!fifo_full) begin
          push     = 1'b1;
          last_evt = 1'b1;
          acc_d    = '0;
          lane_d   = '0;
          stale_d  = '0;
        end
      end else begin
        stale_d = stale_q + 1'b1;
      end
    end else begin
      stale_d = '0;
    end
    if (clr) begin
      lane_d   = '0;
      acc_d    = '0;
      stale_d  = '0;
      push     = 1'b0;
      last_evt = 1'b0;
      ovf_evt  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q  <= '0;
      acc_q   <= '0;
      stale_q <= '0;
    end else begin
      lane_q  <= lane_d;
      acc_q   <= acc_d;
      stale_q <= stale_d;
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push,
  input  logic [W-1:0]    push_data,
  input  logic            pop,
  output logic [W-1:0]    head,
  output logic [CNTW-1:0] count,
  output logic            full
);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            push_e, pop_e;

  assign full   = (cnt_q == CNTW'(DEPTH));
  assign push_e = push && !full;
  assign pop_e  = pop && (cnt_q != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_e && wptr_q == PW'(i)) mem[i] <= push_data;
    end
  end

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_e) wptr_d = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop_e)  rptr_d = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (push_e && !pop_e)      cnt_d = cnt_q + 1'b1;
    else if (pop_e && !push_e) cnt_d = cnt_q - 1'b1;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/uart_rx_seq.sv
module uart_rx_seq
  import uart_rx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int STALE_BITS = 160,
  parameter int FIFO_DEPTH = 4,
  parameter int WM_LEVEL   = 2,
  parameter int AW         = 8,
  parameter int DW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);

  localparam int CNTW = $clog2(FIFO_DEPTH + 1);
  localparam logic [DW-1:0] IRQ_MASK = (DW'(1) << IRQ_CMDDONE) | (DW'(1) << IRQ_ABORTDONE) |
                                       (DW'(1) << IRQ_WM) | (DW'(1) << IRQ_LAST) |
                                       (DW'(1) << IRQ_OVF);

  logic            active_q, active_d;
  logic            abort_q, abort_d;
  logic [DW-1:0]   irq_q, irq_d, ien_q, ien_d;
  logic [DW-1:0]   irq_set, irq_clr;
  logic            start_req, abort_req, soft_clr, rx_clr, pop;
  logic            chr_vld, line_busy, pk_push, pk_last, pk_ovf, fifo_full;
  logic [7:0]      chr_data;
  logic [DW-1:0]   pk_data, fifo_head;
  logic [CNTW-1:0] fcnt;

  assign start_req = bus_wr && bus_addr == AW'(ADR_CMD) && bus_wdata[31:27] == OPC_READ;
  assign abort_req = bus_wr && bus_addr == AW'(ADR_CTRL) && bus_wdata[BIT_ABORT];
  assign soft_clr  = bus_wr && bus_addr == AW'(ADR_FDEF) && bus_wdata[BIT_FDEF];
  assign irq_clr   = (bus_wr && bus_addr == AW'(ADR_ICLR)) ? bus_wdata : '0;
  assign pop       = bus_rd && bus_addr == AW'(ADR_FDATA);
  assign rx_clr    = soft_clr | abort_q;

  uart_rx_sampler #(.OSR(OSR)) u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rx_clr),
    .en       (active_q),
    .rx_line  (rx_line),
    .chr_vld  (chr_vld),
    .chr_data (chr_data),
    .busy     (line_busy)
  );

  uart_rx_packer #(.OSR(OSR), .STALE_BITS(STALE_BITS), .W(DW)) u_pk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rx_clr),
    .chr_vld   (chr_vld),
    .chr_data  (chr_data),
    .line_busy (line_busy),
    .fifo_full (fifo_full),
    .push      (pk_push),
    .push_data (pk_data),
    .last_evt  (pk_last),
    .ovf_evt   (pk_ovf)
  );

  uart_rx_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_clr),
    .push      (pk_push),
    .push_data (pk_data),
    .pop       (pop),
    .head      (fifo_head),
    .count     (fcnt),
    .full      (fifo_full)
  );

  always_comb begin
    active_d = active_q;
    if (start_req) active_d = 1'b1;
    if (abort_q)   active_d = 1'b0;
    abort_d = abort_q ? 1'b0 : abort_req;
    irq_set = '0;
    irq_set[IRQ_CMDDONE]   = abort_q;
    irq_set[IRQ_ABORTDONE] = abort_q;
    irq_set[IRQ_WM]        = (fcnt >= CNTW'(WM_LEVEL));
    irq_set[IRQ_LAST]      = pk_last;
    irq_set[IRQ_OVF]       = pk_ovf;
    irq_d = ((irq_q & ~irq_clr) | irq_set) & IRQ_MASK;
    ien_d = (bus_wr && bus_addr == AW'(ADR_IEN)) ? bus_wdata : ien_q;
    if (soft_clr) begin
      active_d = 1'b0;
      abort_d  = 1'b0;
      irq_d    = '0;
      ien_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      abort_q  <= 1'b0;
      irq_q    <= '0;
      ien_q    <= '0;
    end else begin
      active_q <= active_d;
      abort_q  <= abort_d;
      irq_q    <= irq_d;
      ien_q    <= ien_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(ADR_CTRL):  bus_rdata[BIT_ABORT]  = abort_q;
      AW'(ADR_STAT):  bus_rdata[BIT_ACTIVE] = active_q;
      AW'(ADR_IRQ):   bus_rdata = irq_q;
      AW'(ADR_IEN):   bus_rdata = ien_q;
      AW'(ADR_FSTAT): bus_rdata = DW'(fcnt);
      AW'(ADR_FDATA): bus_rdata = (fcnt != '0) ? fifo_head : '0;
      default:        bus_rdata = '0;
    endcase
  end

  assign irq = |(irq_q & ien_q);

endmodule

// File: rtl/uart_rx_seq_chk.sv
module uart_rx_seq_chk #(
  parameter int DEPTH = 4,
  parameter int WM    = 2,
  parameter int CNTW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            active,
  input logic            abort_pend,
  input logic            soft_clr,
  input logic [CNTW-1:0] fcnt,
  input logic [31:0]     irq_stat
);

  // R8: an abort finishes in the following cycle and reports completion
  assert_abort_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pend && !soft_clr) |=> (!abort_pend && !active && irq_stat[5] && irq_stat[0]));

  // R7: the FIFO never holds more than its depth
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= CNTW'(DEPTH));

  // R6: a level at the watermark raises the watermark flag
  assert_wm_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt >= CNTW'(WM) && !soft_clr) |=> irq_stat[26]);

  // R2: nothing enters the FIFO while the receiver is disarmed
  assert_idle_no_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> fcnt <= $past(fcnt));

  // R10: force-default empties the receiver
  assert_force_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (fcnt == '0 && !active && irq_stat == 32'd0));

endmodule

bind uart_rx_seq uart_rx_seq_chk #(.DEPTH(FIFO_DEPTH), .WM(WM_LEVEL), .CNTW(CNTW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .active     (active_q),
  .abort_pend (abort_q),
  .soft_clr   (soft_clr),
  .fcnt       (fcnt),
  .irq_stat   (irq_q)
);

// File: tb/tb_uart_rx_seq.sv
`timescale 1ns/1ps
module tb_uart_rx_seq;

  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 16;
  localparam int STALE_CLKS = OSR * 160;
  localparam int WDOG       = 150000;

  localparam logic [7:0] A_CMD = 8'h00, A_CTRL = 8'h04, A_STAT = 8'h08, A_IRQ = 8'h0C,
                         A_ICLR = 8'h10, A_IEN = 8'h14, A_FSTAT = 8'h18, A_FDATA = 8'h1C,
                         A_FDEF = 8'h20;

  // stimulus characters and the FIFO count expected after each one
  localparam logic [7:0] TBL_CHR [8] = '{8'h41, 8'h5A, 8'h00, 8'hFF, 8'h81, 8'h7E, 8'h3C, 8'hC3};
  localparam int         TBL_CNT [8] = '{0, 0, 0, 1, 1, 1, 1, 2};

  logic        clk, rst_n, rx_line, bus_wr, bus_rd, irq;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rd;
  int          checks, errors, cyc;
  logic        done;

  uart_rx_seq dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected <%0d", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdr(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop_lvl);
    rx_line = 1'b0; idle(OSR);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i]; idle(OSR);
    end
    rx_line = stop_lvl; idle(OSR);
    rx_line = 1'b1;
  endtask

  initial begin
    logic [31:0] exp_w;
    checks = 0; errors = 0; cyc = 0; done = 1'b0;
    rx_line = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    peek(A_STAT, rd);  chk("R1 status", rd, 32'h0);
    peek(A_FSTAT, rd); chk("R1 count", rd, 32'h0);
    peek(A_IRQ, rd);   chk("R1 flags", rd, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2 line ignored while disarmed, wrong opcode ignored
    send(8'h55, 1'b1); idle(OSR);
    peek(A_FSTAT, rd); chk("R2 unarmed count", rd, 32'h0);
    wr(A_CMD, 32'h1000_0000);
    peek(A_STAT, rd); chk("R2 other opcode", rd, 32'h0);
    wr(A_CMD, 32'h0800_0000);
    peek(A_STAT, rd); chk("R2 armed", rd, 32'h0000_1000);
    wr(A_IEN, 32'h0400_0000);

    // R4 table walk: packing and count
    for (int i = 0; i < 8; i++) begin
      send(TBL_CHR[i], 1'b1);
      peek(A_FSTAT, rd); chk("R4 count", rd, TBL_CNT[i]);
    end
    // R6 / R9 watermark flag and interrupt
    peek(A_IRQ, rd); chk("R6 wm flag", rd & 32'h0400_0000, 32'h0400_0000);
    chk("R9 irq high", {31'd0, irq}, 32'h1);
    for (int e = 0; e < 2; e++) begin
      exp_w = {TBL_CHR[4*e+3], TBL_CHR[4*e+2], TBL_CHR[4*e+1], TBL_CHR[4*e]};
      rdr(A_FDATA, rd); chk("R4 packed element", rd, exp_w);
    end
    peek(A_FSTAT, rd); chk("R4 drained", rd, 32'h0);
    wr(A_ICLR, 32'hFFFF_FFFF);
    peek(A_IRQ, rd); chk("R9 cleared", rd, 32'h0);
    chk("R9 irq low", {31'd0, irq}, 32'h0);

    // R3 short glitch rejected
    rx_line = 1'b0; idle(3); rx_line = 1'b1; idle(12 * OSR);
    peek(A_STAT, rd); chk("R3 still armed", rd, 32'h0000_1000);
    send(8'hA1, 1'b1); send(8'hB2, 1'b1); send(8'hC3, 1'b1);
    // R5 stale flush timing
    idle(STALE_CLKS - 60);
    peek(A_FSTAT, rd); chk("R5 not yet flushed", rd, 32'h0);
    idle(100);
    peek(A_FSTAT, rd); chk("R5 flushed", rd, 32'h1);
    peek(A_IRQ, rd); chk("R5 last flag", rd & 32'h0800_0000, 32'h0800_0000);
    rdr(A_FDATA, rd); chk("R5 R3 partial element", rd, 32'h00C3_B2A1);
    wr(A_ICLR, 32'hFFFF_FFFF);

    // R11 bad stop dropped, receiver recovers
    send(8'h5A, 1'b0); idle(2 * OSR);
    send(8'h33, 1'b1); idle(STALE_CLKS + 40);
    peek(A_FSTAT, rd); chk("R11 one element", rd, 32'h1);
    rdr(A_FDATA, rd); chk("R11 only good char", rd, 32'h0000_0033);
    wr(A_ICLR, 32'hFFFF_FFFF);

    // R7 overflow
    for (int i = 0; i < 16; i++) send(8'h10 + 8'(i), 1'b1);
    peek(A_FSTAT, rd); chk("R7 full", rd, 32'h4);
    send(8'hEE, 1'b1);
    peek(A_FSTAT, rd); chk("R7 count held", rd, 32'h4);
    peek(A_IRQ, rd); chk("R7 overflow flag", rd & 32'h1000_0000, 32'h1000_0000);
    for (int e = 0; e < 4; e++) begin
      exp_w = {8'h13 + 8'(4*e), 8'h12 + 8'(4*e), 8'h11 + 8'(4*e), 8'h10 + 8'(4*e)};
      rdr(A_FDATA, rd); chk("R7 kept elements", rd, exp_w);
    end
    wr(A_ICLR, 32'hFFFF_FFFF);

    // R8 abort
    send(8'h61, 1'b1); send(8'h62, 1'b1);
    wr(A_CTRL, 32'h2);
    peek(A_CTRL, rd); chk("R8 pending", rd, 32'h2);
    peek(A_CTRL, rd); chk("R8 complete", rd, 32'h0);
    peek(A_STAT, rd); chk("R8 disarmed", rd, 32'h0);
    peek(A_IRQ, rd); chk("R8 done flags", rd, 32'h0000_0021);
    idle(STALE_CLKS + 40);
    peek(A_FSTAT, rd); chk("R8 partial dropped", rd, 32'h0);

    // R10 force default
    wr(A_CMD, 32'h0800_0000);
    wr(A_IEN, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) send(8'h70 + 8'(i), 1'b1);
    wr(A_FDEF, 32'h1);
    peek(A_STAT, rd);  chk("R10 status", rd, 32'h0);
    peek(A_FSTAT, rd); chk("R10 count", rd, 32'h0);
    peek(A_IRQ, rd);   chk("R10 flags", rd, 32'h0);
    peek(A_IEN, rd);   chk("R10 enables", rd, 32'h0);
    chk("R10 irq", {31'd0, irq}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule